// File: doc/BRIEF.md
# Random Memory Tag Generator

The block hands out 4-bit allocation tags for a pointer-tagging scheme. The tag sits in bits 59:56 of a 64-bit pointer. A state register holds a 16-bit pseudo-random seed and the most recently produced tag. A request can use one of two modes:

- **Random mode** advances the seed by four shift-register steps to draw a 4-bit offset. It then walks the ring of sixteen tag values, starting from the stored tag. The walk skips every tag whose bit is set in the exclusion mask. The chosen tag is written into the caller's pointer.
- **Adjust mode** starts from the tag already present in the pointer. It walks by a caller-supplied offset under the same skipping rules. It also moves the address by a signed byte offset.

The walk is sequential and visits one ring position per cycle. Requests therefore enter over a valid/ready channel and results leave over a second one.

- **Request channel:** `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- **Response channel:** `rsp_valid` stays high and `rsp_ptr` stays unchanged until a rising edge with `rsp_ready` high. That edge returns the block to idle.
- **Outstanding work:** at most one request is in flight at a time.

Seeding from an entropy source and software access to the state are replaced by a plain load strobe. `cfg_excl` is a plain configuration input that is sampled when a request is accepted.

Top module: `mtag_gen`

## Requirements
- R1: In random mode the seed is stepped four times. Each step computes a feedback bit as the XOR of seed bits 5, 3, 2 and 0, shifts the seed right by one and places the feedback bit in bit 15. The feedback bit of step i becomes bit i of the offset (step 0 gives the LSB). The stepped seed appears in `st_state[23:8]` on the cycle after acceptance.
- R2: In random mode the exclusion mask is `req_excl | cfg_excl` and the walk starts from `st_state[3:0]`. Once the response is valid, `st_state[3:0]` holds the produced tag. `st_state[7:4]` always reads 0.
- R3: When the effective exclusion mask is 16'hFFFF, the result tag is 0 whatever the start tag and offset.
- R4: With offset 0, the start tag is returned if its exclusion bit (bit number = tag value) is clear. Otherwise the tag steps up by one modulo 16 until it reaches a clear bit.
- R5: With offset n > 0, the walk is repeated n times. Each repeat advances the tag by one modulo 16 at least once and keeps advancing while the tag's exclusion bit is set.
- R6: `rsp_ptr` carries the result tag in bits 59:56. In random mode every other bit equals `req_ptr`.
- R7: Adjust mode (`req_mode`=1) works as follows:
  - the start tag is `req_ptr[59:56]`, the offset is `req_tag_ofs` and the mask is `cfg_excl` alone;
  - `rsp_ptr` is `req_ptr` plus the sign-extended `req_addr_ofs`, with bits 59:56 then replaced by the result tag;
  - the state register is unchanged.
- R8: `req_ready` is high only when idle and never together with `rsp_valid`. While `rsp_ready` is low, `rsp_valid` and `rsp_ptr` hold. After reset `req_ready`=1 and `rsp_valid`=0.
- R9: Counting the acceptance edge as edge 1, `rsp_valid` is first seen after edge k+1. Here k is 0 for an all-ones mask. Otherwise k is the number of ring positions the walk examines: for offset 0, the examined tags including the start tag; for offset n > 0, the single-step advances.
- R10: Reset clears the state to 0. A load strobe writes `st_load_seed` and `st_load_tag` into the state on the next edge. A load takes precedence over the seed update of a random request accepted on the same edge. A later tag update made when that request completes is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_excl | input | 16 | Configured exclusion mask, bit t excludes tag t |
| st_load_valid | input | 1 | Strobe that loads the state register |
| st_load_seed | input | 16 | Seed value to load |
| st_load_tag | input | 4 | Tag value to load |
| st_state | output | 24 | State: seed in 23:8, zero in 7:4, last tag in 3:0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 1 | 0 = random, 1 = adjust |
| req_ptr | input | 64 | Input pointer |
| req_excl | input | 16 | Operand exclusion mask (random mode) |
| req_tag_ofs | input | 4 | Tag offset (adjust mode) |
| req_addr_ofs | input | 16 | Signed byte offset (adjust mode) |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_ptr | output | 64 | Tagged output pointer |

## Verification
The response latency depends on the data. The bench counts rising edges from the acceptance edge and samples on falling edges. It compares the edge on which `rsp_valid` first appears with k+1, where k comes from its own model of the ring walk. The seed in `st_state` is due one edge after acceptance and the stored tag on the edge the response becomes valid. Both are therefore checked in the first cycle `rsp_valid` is seen. Back-pressure is checked by holding `rsp_ready` low for several cycles and sampling `rsp_ptr` and `req_ready` on each of them.

// File: rtl/mtag_pkg.sv
package mtag_pkg;
  parameter int TAG_W   = 4;
  parameter int NTAGS   = 1 << TAG_W;
  parameter int SEED_W  = 16;
  parameter int STATE_W = SEED_W + 2 * TAG_W;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [NTAGS-1:0]  mask_t;
  typedef logic [SEED_W-1:0] seed_t;

  typedef enum logic [1:0] {PH_IDLE, PH_WALK, PH_DONE} phase_t;

  // Feedback bit of the seed shift register.
  function automatic logic lfsr_fb(seed_t s);
    return s[5] ^ s[3] ^ s[2] ^ s[0];
  endfunction

  // Seed after one full draw of TAG_W steps.
  function automatic seed_t seed_after(seed_t s);
    seed_t v = s;
    for (int i = 0; i < TAG_W; i++) v = {lfsr_fb(v), v[SEED_W-1:1]};
    return v;
  endfunction
endpackage

// File: rtl/mtag_lfsr.sv
module mtag_lfsr
  import mtag_pkg::*;
(
  input  seed_t seed_in,
  output tag_t  draw_ofs,
  output seed_t seed_out
);
  seed_t chain [TAG_W+1];
  logic [TAG_W-1:0] fb;

  assign chain[0] = seed_in;

  for (genvar gi = 0; gi < TAG_W; gi++) begin : g_step
    assign fb[gi]       = lfsr_fb(chain[gi]);
    assign chain[gi+1]  = {fb[gi], chain[gi][SEED_W-1:1]};
  end

  assign draw_ofs = fb;
  assign seed_out = chain[TAG_W];
endmodule

// File: rtl/mtag_walk.sv
module mtag_walk
  import mtag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  tag_t  start_tag,
  input  tag_t  step_ofs,
  input  mask_t excl,
  output logic  fin,
  output tag_t  fin_tag
);
  logic  busy;
  logic  zmode;
  tag_t  cur, rem;
  mask_t excl_q;
  tag_t  nxt;
  logic  hit, last;

  always_comb begin
    nxt     = cur + tag_t'(1);
    hit     = zmode ? !excl_q[cur] : !excl_q[nxt];
    last    = zmode || (rem == tag_t'(1));
    fin     = busy && hit && last;
    fin_tag = zmode ? cur : nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      zmode  <= 1'b0;
      cur    <= '0;
      rem    <= '0;
      excl_q <= '0;
    end else if (go) begin
      busy   <= 1'b1;
      cur    <= start_tag;
      rem    <= step_ofs;
      zmode  <= (step_ofs == '0);
      excl_q <= excl;
    end else if (busy) begin
      if (fin) begin
        busy <= 1'b0;
      end else begin
        cur <= nxt;
        if (!zmode && hit) rem <= rem - tag_t'(1);
      end
    end
  end
endmodule

// File: rtl/mtag_ptr.sv
module mtag_ptr #(
  parameter int PTR_W  = 64,
  parameter int AOFS_W = 16
) (
  input  logic              adjust,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [AOFS_W-1:0] addr_ofs,
  output logic [PTR_W-1:0]  ptr_base
);
  localparam int EXT_W = PTR_W - AOFS_W;
  logic [PTR_W-1:0] ofs_ext;

  assign ofs_ext  = {{EXT_W{addr_ofs[AOFS_W-1]}}, addr_ofs};
  assign ptr_base = adjust ? (ptr_in + ofs_ext) : ptr_in;
endmodule

// File: rtl/mtag_gen.sv
module mtag_gen
  import mtag_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56,
  parameter int AOFS_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTAGS-1:0]    cfg_excl,
  input  logic                st_load_valid,
  input  logic [SEED_W-1:0]   st_load_seed,
  input  logic [TAG_W-1:0]    st_load_tag,
  output logic [STATE_W-1:0]  st_state,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_mode,
  input  logic [PTR_W-1:0]    req_ptr,
  input  logic [NTAGS-1:0]    req_excl,
  input  logic [TAG_W-1:0]    req_tag_ofs,
  input  logic [AOFS_W-1:0]   req_addr_ofs,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [PTR_W-1:0]    rsp_ptr
);
  phase_t           phase;
  seed_t            seed_q;
  tag_t             tag_q;
  logic             mode_q;
  logic [PTR_W-1:0] base_q, rsp_q;

  logic             acc, all_ex, fin;
  tag_t             draw_ofs, start_tag, step_ofs, fin_tag;
  seed_t            seed_nx;
  mask_t            eff_excl;
  logic [PTR_W-1:0] base;

  mtag_lfsr u_lfsr (
    .seed_in  (seed_q),
    .draw_ofs (draw_ofs),
    .seed_out (seed_nx)
  );

  mtag_ptr #(.PTR_W(PTR_W), .AOFS_W(AOFS_W)) u_ptr (
    .adjust   (req_mode),
    .ptr_in   (req_ptr),
    .addr_ofs (req_addr_ofs),
    .ptr_base (base)
  );

  always_comb begin
    req_ready = (phase == PH_IDLE);
    acc       = req_valid && req_ready;
    start_tag = req_mode ? req_ptr[TAG_LSB +: TAG_W] : tag_q;
    step_ofs  = req_mode ? req_tag_ofs : draw_ofs;
    eff_excl  = req_mode ? cfg_excl : (req_excl | cfg_excl);
    all_ex    = &eff_excl;
  end

  mtag_walk u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (acc && !all_ex),
    .start_tag (start_tag),
    .step_ofs  (step_ofs),
    .excl      (eff_excl),
    .fin       (fin),
    .fin_tag   (fin_tag)
  );

  // Channel phase and result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      mode_q <= 1'b0;
      base_q <= '0;
      rsp_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (acc) begin
          mode_q <= req_mode;
          base_q <= base;
          if (all_ex) begin
            rsp_q                    <= base;
            rsp_q[TAG_LSB +: TAG_W]  <= '0;
            phase                    <= PH_DONE;
          end else begin
            phase <= PH_WALK;
          end
        end
        PH_WALK: if (fin) begin
          rsp_q                   <= base_q;
          rsp_q[TAG_LSB +: TAG_W] <= fin_tag;
          phase                   <= PH_DONE;
        end
        PH_DONE: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Seed and last-tag state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seed_q <= '0;
      tag_q  <= '0;
    end else if (st_load_valid) begin
      seed_q <= st_load_seed;
      tag_q  <= st_load_tag;
    end else begin
      if (acc && !req_mode) begin
        seed_q <= seed_nx;
        if (all_ex) tag_q <= '0;
      end
      if (fin && !mode_q) tag_q <= fin_tag;
    end
  end

  assign st_state  = {seed_q, {TAG_W{1'b0}}, tag_q};
  assign rsp_valid = (phase == PH_DONE);
  assign rsp_ptr   = rsp_q;
endmodule

// File: rtl/mtag_gen_chk.sv
module mtag_gen_chk
  import mtag_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NTAGS-1:0]   cfg_excl,
  input logic               st_load_valid,
  input logic [STATE_W-1:0] st_state,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_mode,
  input logic [PTR_W-1:0]   req_ptr,
  input logic [NTAGS-1:0]   req_excl,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PTR_W-1:0]   rsp_ptr
);
  localparam int LIMIT = NTAGS * NTAGS;
  localparam logic [PTR_W-1:0] TMASK = {{(PTR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

  mask_t            eff_q;
  logic             mode_q;
  logic [PTR_W-1:0] ptr_q;
  int               wait_cnt;
  logic             acc, acc_rand;
  tag_t             out_tag;

  assign acc      = req_valid && req_ready;
  assign acc_rand = acc && !req_mode && !st_load_valid;
  assign out_tag  = rsp_ptr[TAG_LSB +: TAG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q    <= '0;
      mode_q   <= 1'b0;
      ptr_q    <= '0;
      wait_cnt <= 0;
    end else begin
      if (acc) begin
        eff_q  <= req_mode ? cfg_excl : (req_excl | cfg_excl);
        mode_q <= req_mode;
        ptr_q  <= req_ptr;
      end
      if (req_ready || rsp_valid) wait_cnt <= 0;
      else                        wait_cnt <= wait_cnt + 1;
    end
  end

  p_seed_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rand |=> st_state[STATE_W-1 -: SEED_W] == seed_after($past(st_state[STATE_W-1 -: SEED_W])));

  p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_state[2*TAG_W-1:TAG_W] == '0);

  p_all_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (&eff_q)) |-> out_tag == '0);

  p_not_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(&eff_q)) |-> !eff_q[out_tag]);

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !mode_q) |-> ((rsp_ptr & ~TMASK) == (ptr_q & ~TMASK)));

  p_one_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ptr)));

  p_walk_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= LIMIT);
endmodule

bind mtag_gen mtag_gen_chk #(.PTR_W(PTR_W), .TAG_LSB(TAG_LSB)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_excl      (cfg_excl),
  .st_load_valid (st_load_valid),
  .st_state      (st_state),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_mode      (req_mode),
  .req_ptr       (req_ptr),
  .req_excl      (req_excl),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_ptr       (rsp_ptr)
);

// File: tb/test_mtag_gen.sv
module test_mtag_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_excl = '0;
  logic        st_load_valid = 1'b0;
  logic [15:0] st_load_seed = '0;
  logic [3:0]  st_load_tag = '0;
  logic [23:0] st_state;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_mode = 1'b0;
  logic [63:0] req_ptr = '0;
  logic [15:0] req_excl = '0;
  logic [3:0]  req_tag_ofs = '0;
  logic [15:0] req_addr_ofs = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_ptr;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_seed = '0;
  logic [3:0]  m_tag = '0;
  bit          done = 0;

  always #4 clk = ~clk;

  mtag_gen i_mtag_gen (
    .clk(clk), .rst_n(rst_n), .cfg_excl(cfg_excl),
    .st_load_valid(st_load_valid), .st_load_seed(st_load_seed), .st_load_tag(st_load_tag),
    .st_state(st_state), .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_ptr(req_ptr), .req_excl(req_excl), .req_tag_ofs(req_tag_ofs),
    .req_addr_ofs(req_addr_ofs), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ptr(rsp_ptr)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic void m_draw(input logic [15:0] s, output logic [3:0] o, output logic [15:0] ns);
    logic fb;
    for (int i = 0; i < 4; i++) begin
      fb   = s[5] ^ s[3] ^ s[2] ^ s[0];
      s    = {fb, s[15:1]};
      o[i] = fb;
    end
    ns = s;
  endfunction

  function automatic void m_pick(input logic [3:0] st, input logic [3:0] of, input logic [15:0] ex,
                                 output logic [3:0] t, output int k);
    t = st;
    k = 0;
    if (ex == 16'hFFFF) begin
      t = 0;
    end else if (of == 0) begin
      k = 1;
      while (ex[t]) begin t = t + 4'd1; k++; end
    end else begin
      for (int n = 0; n < of; n++) begin
        t = t + 4'd1; k++;
        while (ex[t]) begin t = t + 4'd1; k++; end
      end
    end
  endfunction

  task automatic do_load(input logic [15:0] s, input logic [3:0] t);
    @(negedge clk);
    st_load_valid = 1'b1; st_load_seed = s; st_load_tag = t;
    @(posedge clk);
    @(negedge clk);
    st_load_valid = 1'b0;
    m_seed = s; m_tag = t;
    chk(st_state == {s, 4'h0, t}, "R10 load state", 64'(st_state), 64'({s, 4'h0, t}));
  endtask

  task automatic run_req(input bit mode, input logic [63:0] ptr, input logic [15:0] rex,
                         input logic [15:0] cex, input logic [3:0] tofs, input logic [15:0] aofs,
                         input bit hold, input bit coll, input logic [15:0] lseed,
                         input logic [3:0] ltag, input string rq);
    logic [3:0]  dofs, st, of, t;
    logic [15:0] ns, ex;
    logic [63:0] exp_ptr;
    int k, edges;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 idle ready", 64'(req_ready), 64'd1);
    m_draw(m_seed, dofs, ns);
    st = mode ? ptr[59:56] : m_tag;
    of = mode ? tofs : dofs;
    ex = mode ? cex : (rex | cex);
    m_pick(st, of, ex, t, k);
    exp_ptr = mode ? ptr + {{48{aofs[15]}}, aofs} : ptr;
    exp_ptr[59:56] = t;
    req_mode = mode; req_ptr = ptr; req_excl = rex; cfg_excl = cex;
    req_tag_ofs = tofs; req_addr_ofs = aofs; req_valid = 1'b1;
    rsp_ready = !hold;
    if (coll) begin st_load_valid = 1'b1; st_load_seed = lseed; st_load_tag = ltag; end
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    req_valid = 1'b0; st_load_valid = 1'b0;
    while (!rsp_valid && edges < 400) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    if (!mode) begin
      m_seed = coll ? lseed : ns;
      m_tag  = t;
    end else if (coll) begin
      m_seed = lseed; m_tag = ltag;
    end
    chk(rsp_valid == 1'b1, {rq, " R9 response arrives"}, 64'(rsp_valid), 64'd1);
    chk(edges == k + 1, {rq, " R9 latency"}, 64'(edges), 64'(k + 1));
    chk(rsp_ptr == exp_ptr, {rq, " result pointer"}, rsp_ptr, exp_ptr);
    chk(st_state == {m_seed, 4'h0, m_tag}, {rq, " R2 state"}, 64'(st_state), 64'({m_seed, 4'h0, m_tag}));
    if (hold) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_ptr == exp_ptr && !req_ready, "R8 hold under back-pressure",
            rsp_ptr, exp_ptr);
      end
      rsp_ready = 1'b1;
    end
    @(posedge clk);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_state == 24'h0, "R10 reset state", 64'(st_state), 64'h0);
    chk(req_ready && !rsp_valid, "R8 reset channel", 64'({req_ready, rsp_valid}), 64'b10);

    // R3: all tags excluded by configuration
    do_load(16'hACE1, 4'd5);
    run_req(1'b0, 64'h0123_4567_89AB_CDEF, 16'h0000, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R3 all-excluded");
    // R3 via operand mask OR, in adjust mode too
    run_req(1'b0, 64'h0F00_0000_0000_1000, 16'hF0F0, 16'h0F0F, 0, 0, 0, 0, 0, 0, "R3 or-mask");
    run_req(1'b1, 64'h0500_0000_0000_0040, 16'h0000, 16'hFFFF, 4'd3, 16'h0010, 0, 0, 0, 0, "R3 adjust");

    // R4: zero seed gives offset 0
    do_load(16'h0000, 4'd7);
    run_req(1'b0, 64'h0, 16'h0001, 16'h0000, 0, 0, 0, 0, 0, 0, "R4 start kept");
    run_req(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0080, 16'h0100, 0, 0, 0, 0, 0, 0, "R4 start skipped");
    run_req(1'b0, 64'h0, 16'h7FFF, 16'h0000, 0, 0, 0, 0, 0, 0, "R4 wrap to 15");

    // R5 / R7: adjust with wrap and skipped tags
    run_req(1'b1, 64'h0E00_0000_0000_0100, 16'hFFFF, 16'h8002, 4'd3, 16'hFFF0, 0, 0, 0, 0, "R7 R5 adjust wrap");
    run_req(1'b1, 64'h0900_0000_0000_0000, 16'h0000, 16'h0000, 4'd0, 16'h8000, 0, 0, 0, 0, "R7 adjust zero offset");
    run_req(1'b1, 64'h0000_FFFF_FFFF_FFF0, 16'h0000, 16'h7FFE, 4'd15, 16'h0020, 0, 0, 0, 0, "R7 R5 carry and long walk");

    // R1: seeded draw, plus R8 back-pressure
    do_load(16'hB400, 4'd2);
    run_req(1'b0, 64'h00AA_5555_0000_1234, 16'h0010, 16'h0000, 0, 0, 1, 0, 0, 0, "R1 R8 seeded draw hold");

    // R10: load collides with a random request
    run_req(1'b0, 64'h1234_0000_0000_0000, 16'h0000, 16'h0003, 0, 0, 0, 1, 16'h1357, 4'd9, "R10 load collision");

    // Random mixture: R1 R2 R5 R6 R7
    for (int i = 0; i < 300; i++) begin
      logic [15:0] rx, cx;
      bit md;
      md = ($urandom % 3) == 0;
      rx = $urandom; cx = $urandom;
      case ($urandom % 4)
        0: begin rx = rx & $urandom; cx = cx & $urandom & $urandom; end
        1: begin rx = 16'h0; cx = cx & $urandom; end
        2: cx = 16'h0;
        default: ;
      endcase
      if ($urandom % 25 == 0) cx = 16'hFFFF;
      run_req(md, {$urandom, $urandom}, rx, cx, 4'($urandom), 16'($urandom),
              ($urandom % 10) == 0, 0, 0, 0, md ? "R7 R5 random" : "R1 R2 R6 random");
      if (i % 60 == 59) do_load(16'($urandom) | 16'h1, 4'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule